// File: doc/BRIEF.md
# Steerable Processor Watchdog

This block watches a processor for signs of life. Software programs one 8-bit control register with three fields: a timeout multiplier, a code that picks one of four time bases, and a steering bit. Any read or write of that register is treated as the processor's heartbeat and restarts the count. If no access arrives before the programmed number of time-base ticks have elapsed, the watchdog expires.

The steering bit decides what an expiry does. With steering clear, a sticky flag is set and an active-low interrupt line is driven. Both stay until software reads the flag or touches the control register. With steering set, an active-low reset pulse of a fixed length, timed from the fastest time base, is emitted instead. The control register is also wiped to zero, which disarms the watchdog. A one-cycle strobe tells the neighbouring logic to drop its frequency-test enable.

The time bases arrive as single-cycle tick strobes from a divider outside the block. Bit 0 is the 1/16 s tick, bit 1 the 1/4 s tick, bit 2 the 1 s tick and bit 3 the 4 s tick. Power-up is the asynchronous active-low reset.

Top module: `wdog_steer`

## Requirements
- R1: While and after reset, the control register reads 00h, the interrupt and reset-pulse lines are high (inactive), the flag is 0 and the test-clear strobe is 0.
- R2: A write stores the byte so that bit 7 is the steering bit, bits 6..2 are the multiplier and bits 1..0 are the resolution code. The stored value is visible on `cfg_q_o` from the cycle after the write.
- R3: Resolution code c selects tick input bit c (0: 1/16 s, 1: 1/4 s, 2: 1 s, 3: 4 s). The watchdog expires on the M-th selected tick after the last register access, where M is the multiplier, and not before. The outputs change in the cycle after that tick.
- R4: A read or write of the control register restarts the count, and no expiry takes effect in the cycle after an access.
- R5: With a multiplier of zero the watchdog never expires, whatever the steering and resolution bits hold.
- R6: With steering 0, expiry sets the flag and drives `irq_n_o` low. Both hold until a flag read or a control-register read or write clears them.
- R7: With steering 1, expiry drives `rst_pulse_n_o` low and leaves the flag alone. The pulse is released in the cycle after the PULSE_TICKS-th 1/16 s tick that follows the expiry (default 2, so 62.5 to 125 ms).
- R8: With steering 1, the expiry clears the control register to 00h and raises `ft_clr_o` for exactly one cycle, the same cycle the reset pulse starts.
- R9: Ticks on the unselected time-base inputs do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_rd_i | input | 1 | Control register read strobe |
| reg_wdata_i | input | 8 | Write data for the control register |
| flag_rd_i | input | 1 | Read strobe of the register that holds the flag |
| tick_base_i | input | 4 | Time-base tick strobes: 1/16 s, 1/4 s, 1 s, 4 s |
| cfg_q_o | output | 8 | Current control register contents |
| irq_n_o | output | 1 | Active-low interrupt request |
| rst_pulse_n_o | output | 1 | Active-low timed reset pulse |
| wdog_flag_o | output | 1 | Sticky watchdog expiry flag |
| ft_clr_o | output | 1 | One-cycle strobe to clear the frequency-test enable |

## Verification
The directed cases use the 3-tick, 1 s setting. They interleave ticks from the other three bases, which shows whether the base selector leaks. A heartbeat read in mid-count shows whether the restart works or the count merely pauses. Zero-multiplier settings paired with a set steering bit or a nonzero resolution show that such settings are treated as disabled. Random cases then draw the steering, resolution and a small multiplier, with stray ticks mixed in. Stopping one tick short of expiry and then giving the final tick pins down the exact tick on which each path fires. That run also shows that the interrupt path and the reset path never set each other's outputs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WD_MULT_W = 5;
  localparam int WD_RES_W  = 2;
  localparam int WD_CFG_W  = 1 + WD_MULT_W + WD_RES_W;

  typedef enum logic [WD_RES_W-1:0] {
    RES_SIXTEENTH = 2'd0,
    RES_QUARTER   = 2'd1,
    RES_ONE_SEC   = 2'd2,
    RES_FOUR_SEC  = 2'd3
  } wd_res_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter int RES_W = wdog_pkg::WD_RES_W
) (
  input  logic [(1<<RES_W)-1:0] tick_base,
  input  logic [RES_W-1:0]      res_code,
  output logic                  sel_tick
);
  localparam int NUM_BASE = 1 << RES_W;

  logic [NUM_BASE-1:0] hit;

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    assign hit[g] = tick_base[g] && (res_code == RES_W'(g));
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int MULT_W = wdog_pkg::WD_MULT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [MULT_W-1:0] mult,
  input  logic              sel_tick,
  output logic              expire
);
  logic [MULT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              armed;
  logic [MULT_W:0]   cnt_inc;

  assign armed   = (mult != '0);
  assign cnt_inc = {1'b0, cnt_q} + (MULT_W+1)'(1);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = 1'b0;
    if (restart || !armed) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (sel_tick) begin
      cnt_en = 1'b1;
      if (cnt_inc >= {1'b0, mult}) begin
        expire = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc[MULT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int CFG_W = wdog_pkg::WD_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             self_clr,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (wr_en) begin
      cfg_d  = wdata;
      cfg_en = 1'b1;
    end else if (self_clr) begin
      cfg_d  = '0;
      cfg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
  parameter int PULSE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic flag_clr,
  input  logic pulse_tick,
  output logic flag_q,
  output logic pulse_q,
  output logic ft_clr_q,
  output logic cfg_clr
);
  localparam int PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PULSE_TICKS - 1);

  logic          to_irq, to_rst;
  logic          flag_d, flag_en;
  logic          pulse_d, pulse_en;
  logic [PW-1:0] pcnt_q, pcnt_d;

  assign to_irq  = expire && !steer;
  assign to_rst  = expire && steer;
  assign cfg_clr = to_rst;

  always_comb begin
    flag_d  = flag_q;
    flag_en = 1'b0;
    if (to_irq) begin
      flag_d  = 1'b1;
      flag_en = 1'b1;
    end else if (flag_clr) begin
      flag_d  = 1'b0;
      flag_en = 1'b1;
    end
  end

  always_comb begin
    pulse_d  = pulse_q;
    pcnt_d   = pcnt_q;
    pulse_en = 1'b0;
    if (to_rst) begin
      pulse_d  = 1'b1;
      pcnt_d   = '0;
      pulse_en = 1'b1;
    end else if (pulse_q && pulse_tick) begin
      pulse_en = 1'b1;
      if (pcnt_q == PLAST) begin
        pulse_d = 1'b0;
        pcnt_d  = '0;
      end else begin
        pcnt_d = pcnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_d;
      pcnt_q  <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_clr_q <= 1'b0;
    end else begin
      ft_clr_q <= to_rst;
    end
  end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W      = wdog_pkg::WD_MULT_W,
  parameter int RES_W       = wdog_pkg::WD_RES_W,
  parameter int PULSE_TICKS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [MULT_W+RES_W:0]     reg_wdata_i,
  input  logic                      flag_rd_i,
  input  logic [(1<<RES_W)-1:0]     tick_base_i,
  output logic [MULT_W+RES_W:0]     cfg_q_o,
  output logic                      irq_n_o,
  output logic                      rst_pulse_n_o,
  output logic                      wdog_flag_o,
  output logic                      ft_clr_o
);
  localparam int CFG_W     = 1 + MULT_W + RES_W;
  localparam int STEER_BIT = CFG_W - 1;
  localparam int MULT_LSB  = RES_W;

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              access;
  logic              sel_tick;
  logic              expire;
  logic              cfg_clr;
  logic              flag_q, pulse_q, ft_clr_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [MULT_W-1:0] mult;
  logic [RES_W-1:0]  res_code;
  logic              steer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  assign access   = reg_wr_i || reg_rd_i;
  assign mult     = cfg_q[MULT_LSB +: MULT_W];
  assign res_code = cfg_q[RES_W-1:0];
  assign steer    = cfg_q[STEER_BIT];

  wdog_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (reg_wr_i),
    .wdata    (reg_wdata_i),
    .self_clr (cfg_clr),
    .cfg_q    (cfg_q)
  );

  wdog_tick_sel #(.RES_W(RES_W)) u_sel (
    .tick_base (tick_base_i),
    .res_code  (res_code),
    .sel_tick  (sel_tick)
  );

  wdog_timer #(.MULT_W(MULT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .restart  (access),
    .mult     (mult),
    .sel_tick (sel_tick),
    .expire   (expire)
  );

  wdog_resp #(.PULSE_TICKS(PULSE_TICKS)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .expire     (expire),
    .steer      (steer),
    .flag_clr   (flag_rd_i || access),
    .pulse_tick (tick_base_i[0]),
    .flag_q     (flag_q),
    .pulse_q    (pulse_q),
    .ft_clr_q   (ft_clr_q),
    .cfg_clr    (cfg_clr)
  );

  assign cfg_q_o       = cfg_q;
  assign irq_n_o       = !flag_q;
  assign wdog_flag_o   = flag_q;
  assign rst_pulse_n_o = !pulse_q;
  assign ft_clr_o      = ft_clr_q;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int CFG_W    = wdog_pkg::WD_CFG_W,
  parameter int RES_W    = wdog_pkg::WD_RES_W,
  parameter int NUM_BASE = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_i,
  input logic                reg_rd_i,
  input logic [CFG_W-1:0]    reg_wdata_i,
  input logic                flag_rd_i,
  input logic [NUM_BASE-1:0] tick_base_i,
  input logic [CFG_W-1:0]    cfg_q_o,
  input logic                irq_n_o,
  input logic                rst_pulse_n_o,
  input logic                wdog_flag_o,
  input logic                ft_clr_o
);
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> cfg_q_o == $past(reg_wdata_i));

  // R4
  access_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i || reg_rd_i) && irq_n_o && rst_pulse_n_o |=> irq_n_o && rst_pulse_n_o);

  // R5
  zero_mult_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q_o[CFG_W-2:RES_W] == '0) && irq_n_o |=> irq_n_o);

  // R5
  zero_mult_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q_o[CFG_W-2:RES_W] == '0) && rst_pulse_n_o |=> rst_pulse_n_o);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o && !flag_rd_i && !reg_rd_i && !reg_wr_i |=> !irq_n_o && wdog_flag_o);

  // R7
  pulse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_n_o) |-> $past(tick_base_i[0]));

  // R8
  pulse_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse_n_o) |-> (cfg_q_o == '0) && ft_clr_o);

  // R8
  ft_clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr_o |=> !ft_clr_o);
endmodule

bind wdog_steer wdog_steer_chk #(
  .CFG_W    (CFG_W),
  .RES_W    (RES_W),
  .NUM_BASE (1 << RES_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .reg_wr_i      (reg_wr_i),
  .reg_rd_i      (reg_rd_i),
  .reg_wdata_i   (reg_wdata_i),
  .flag_rd_i     (flag_rd_i),
  .tick_base_i   (tick_base_i),
  .cfg_q_o       (cfg_q_o),
  .irq_n_o       (irq_n_o),
  .rst_pulse_n_o (rst_pulse_n_o),
  .wdog_flag_o   (wdog_flag_o),
  .ft_clr_o      (ft_clr_o)
);

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;
  localparam int PULSE = 2;

  logic       clk;
  logic       rst_n;
  logic       reg_wr, reg_rd, flag_rd;
  logic [7:0] wdata;
  logic [3:0] tick;
  logic [7:0] cfg_q;
  logic       irq_n, rst_pulse_n, wflag, ft_clr;

  int checks = 0;
  int fails  = 0;

  wdog_steer #(.PULSE_TICKS(PULSE)) u_wdog_steer (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_i      (reg_wr),
    .reg_rd_i      (reg_rd),
    .reg_wdata_i   (wdata),
    .flag_rd_i     (flag_rd),
    .tick_base_i   (tick),
    .cfg_q_o       (cfg_q),
    .irq_n_o       (irq_n),
    .rst_pulse_n_o (rst_pulse_n),
    .wdog_flag_o   (wflag),
    .ft_clr_o      (ft_clr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pack_cfg(input logic st, input int m, input int r);
    return {st, 5'(m), 2'(r)};
  endfunction

  function automatic int ticks_needed(input logic [7:0] v);
    return int'(v[6:2]);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic do_flag_rd();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic pulse_tick(input int b);
    @(negedge clk); tick = 4'(1 << b);
    @(negedge clk); tick = '0;
  endtask

  task automatic stray(input int sel);
    pulse_tick((sel + 1 + int'($urandom % 3)) % 4);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; flag_rd = 1'b0;
    wdata = '0; tick = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(cfg_q == 8'h00 && irq_n && rst_pulse_n && !wflag && !ft_clr, "R1 in reset",
          int'(cfg_q), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cfg_q == 8'h00 && irq_n && rst_pulse_n && !wflag && !ft_clr, "R1 after reset",
          int'({irq_n, rst_pulse_n, wflag, ft_clr}), 4'b1100);

    // R2 field layout: 3 x 1 s
    v = pack_cfg(1'b0, 3, 2);
    do_write(v);
    check(cfg_q == 8'h0E, "R2 readback", int'(cfg_q), 8'h0E);
    pulse_tick(2); pulse_tick(0); pulse_tick(1); pulse_tick(3);
    pulse_tick(2);
    // R9 other bases ignored, R3 not early
    check(irq_n && !wflag, "R9 stray ticks", int'(irq_n), 1);
    pulse_tick(2);
    check(irq_n == 1'b0 && wflag, "R3 expiry on third tick", int'(irq_n), 0);
    check(rst_pulse_n && !ft_clr, "R6 no reset pulse", int'(rst_pulse_n), 1);
    pulse_tick(2); pulse_tick(2);
    check(!irq_n && wflag, "R6 sticky", int'(irq_n), 0);
    do_read();
    check(irq_n && !wflag, "R6 cleared by register read", int'(irq_n), 1);

    // R4 restart in mid-count
    do_write(pack_cfg(1'b0, 2, 2));
    pulse_tick(2);
    do_read();
    pulse_tick(2);
    check(irq_n, "R4 restart on read", int'(irq_n), 1);
    pulse_tick(2);
    check(!irq_n, "R4 expiry after restart", int'(irq_n), 0);
    do_flag_rd();
    check(irq_n && !wflag, "R6 cleared by flag read", int'(wflag), 0);

    // R5 zero multiplier
    do_write(8'h03);
    for (int i = 0; i < 40; i++) pulse_tick(3);
    check(irq_n && rst_pulse_n, "R5 mult 0 res 3", int'(irq_n), 1);
    do_write(8'h80);
    for (int i = 0; i < 40; i++) pulse_tick(0);
    check(irq_n && rst_pulse_n && cfg_q == 8'h80, "R5 mult 0 steer 1",
          int'(rst_pulse_n), 1);

    // R7 R8 steering to reset, 1 x 1/16 s
    do_write(pack_cfg(1'b1, 1, 0));
    pulse_tick(0);
    check(!rst_pulse_n && wflag == 1'b0, "R7 pulse start", int'(rst_pulse_n), 0);
    check(cfg_q == 8'h00 && ft_clr, "R8 clear and strobe", int'(cfg_q), 0);
    @(negedge clk);
    check(!ft_clr, "R8 strobe one cycle", int'(ft_clr), 0);
    pulse_tick(0);
    check(!rst_pulse_n, "R7 pulse held", int'(rst_pulse_n), 0);
    pulse_tick(0);
    check(rst_pulse_n, "R7 pulse released", int'(rst_pulse_n), 1);

    // randomized mix
    for (int it = 0; it < 40; it++) begin
      logic       st;
      int         r, m;
      st = 1'($urandom % 2);
      r  = int'($urandom % 4);
      m  = 1 + int'($urandom % 3);
      v  = pack_cfg(st, m, r);
      do_write(v);
      check(cfg_q == v, "R2 random readback", int'(cfg_q), int'(v));
      for (int k = 0; k < ticks_needed(v) - 1; k++) begin
        stray(r);
        pulse_tick(r);
      end
      check(irq_n && rst_pulse_n, "R3 random not early", int'({irq_n, rst_pulse_n}), 3);
      stray(r);
      pulse_tick(r);
      if (st) begin
        check(!rst_pulse_n && !wflag && irq_n, "R7 random pulse", int'(rst_pulse_n), 0);
        check(cfg_q == 8'h00, "R8 random clear", int'(cfg_q), 0);
        for (int p = 0; p < PULSE; p++) pulse_tick(0);
        check(rst_pulse_n, "R7 random release", int'(rst_pulse_n), 1);
      end else begin
        check(!irq_n && wflag && rst_pulse_n, "R6 random irq", int'(irq_n), 0);
        do_flag_rd();
        check(irq_n && !wflag, "R6 random clear", int'(irq_n), 1);
      end
    end

    summary();
    $finish;
  end
endmodule